// File: doc/BRIEF.md
# GPIO Pin Control Register Bank

This block holds the software-visible configuration of a set of general-purpose pins. Sixteen pins share each 32-bit configuration word. Six per-pin attributes each have their own group of words: direction, output level, input enable, Schmitt-trigger enable, pull enable and pull polarity. Every attribute word can be reached at three addresses. The plain address replaces the whole 16-pin group. The set alias turns on every bit written as 1. The clear alias turns off every bit written as 1. Because of the aliases, software can change one pin without first reading the word back. The pads are sampled through a two-flop synchronizer into a read-only input word.

A second register group holds a 3-bit function select for each pin, packed five pins to a word. A pin drives its pad only when its direction bit says output and its function select is 0, the GPIO function. Software can rewrite a whole packed mode word at once. It can also write one pin's field through a per-pin alias address, which leaves the other four fields of that word untouched.

The register interface is a simple select/write strobe bus. A small two-state controller, BUS_IDLE and BUS_RESP, sequences it. In BUS_IDLE the block is ready. A write is committed at the accepting edge and the controller stays in BUS_IDLE. A read captures its data at the accepting edge and moves the controller to BUS_RESP. BUS_RESP presents the data for one cycle with ready low, then always returns to BUS_IDLE.

Top module: `gpio_pinctrl_bank`

## Requirements
- R1: After reset every attribute bit and every mode field is 0. This means all pins are inputs, pulls are off and the GPIO function is selected, so `pin_oe`, `pin_out` and `cfg_mode` are all 0 and every register reads 0.
- R2: Pin n sits in port word n>>4 at bit n&15. A write to an attribute's base address (attribute base + 4*port) replaces bits 15:0 of that port word. Bits 31:16 are never stored and always read 0.
- R3: A write to base+0x10 sets exactly the bits written as 1 and leaves the others unchanged.
- R4: A write to base+0x20 clears exactly the bits written as 1 and leaves the others unchanged.
- R5: The direction attribute (base 0x000) uses 1 for output and 0 for input. The output-level attribute (base 0x040) drives `pin_out` directly.
- R6: The input word (base 0x180) returns `pin_in` through a two-flop synchronizer. Writes to it and to its aliases have no effect.
- R7: Mode word w (address 0x200 + 4*w) holds pin n = 5*w + s in bits 3*s+2:3*s. A write to a mode word replaces all of its fields. Bits 31:15 and fields of pins beyond the pin count read 0.
- R8: A write to address 0x300 + 4*n loads bits 2:0 of the write data into pin n's mode field and changes no other field.
- R9: `pin_oe[n]` is 1 only when pin n's direction bit is 1 and its mode field is 0.
- R10: `cfg_ien`, `cfg_smt`, `cfg_pull_en` and `cfg_pull_up` follow the input-enable (0x080), Schmitt (0x0C0), pull-enable (0x100) and pull-polarity (0x140, 1 = up) attributes.
- R11: Read data is valid in the cycle after an accepted read, with `bus_rvalid` high and `bus_ready` low. A request presented while `bus_ready` is low is ignored.
- R12: The following read 0 and ignore writes: misaligned addresses, offset 0x30 within an attribute group, port words beyond the pin count, region 0x1C0-0x1FF, mode words beyond the pin count and per-pin mode aliases beyond the pin count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Block can accept a request |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Pad output levels |
| pin_oe | output | NUM_PINS | Pad output enables |
| cfg_ien | output | NUM_PINS | Input buffer enables |
| cfg_smt | output | NUM_PINS | Schmitt-trigger enables |
| cfg_pull_en | output | NUM_PINS | Pull resistor enables |
| cfg_pull_up | output | NUM_PINS | Pull polarity, 1 = up |
| cfg_mode | output | 3*NUM_PINS | Function select per pin |

## Verification
The assertions assume that `bus_sel` is held low while reset is asserted. They also assume that a request is only dropped, never changed, when it is ignored because `bus_ready` is low. The stability checks on `pin_out` and `cfg_mode` depend on every change of those outputs coming from a write seen on the previous edge. For that reason the stimulus changes bus inputs only on falling clock edges and only through the read and write tasks. The single deliberate violation of the ready rule is a write presented during BUS_RESP, and the bench then shows through a register read that this write had no effect.

// File: rtl/gpio_pinctrl_pkg.sv
package gpio_pinctrl_pkg;

    localparam int ADDR_W          = 10;
    localparam int PINS_PER_PORT   = 16;
    localparam int FIELDS_PER_WORD = 5;
    localparam int MODE_W          = 3;
    localparam int N_ATTR          = 6;
    localparam int MWORD_W         = FIELDS_PER_WORD * MODE_W;

    // Attribute order equals address region index (addr[9:6]).
    typedef enum logic [2:0] {
        ATTR_DIR  = 3'd0,
        ATTR_DOUT = 3'd1,
        ATTR_IEN  = 3'd2,
        ATTR_SMT  = 3'd3,
        ATTR_PEN  = 3'd4,
        ATTR_PSEL = 3'd5
    } attr_e;

    // Write operation equals alias index (addr[5:4]).
    typedef enum logic [1:0] {
        WOP_REPLACE = 2'd0,
        WOP_SET     = 2'd1,
        WOP_CLEAR   = 2'd2
    } wop_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_ATTR,
        TGT_DIN,
        TGT_MWORD,
        TGT_MFIELD
    } tgt_e;

    typedef struct packed {
        tgt_e       tgt;
        attr_e      attr;
        wop_e       op;
        logic [1:0] port;
        logic [5:0] idx;
    } dec_t;

    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_st_e;

endpackage

// File: rtl/gpio_pinctrl_dec.sv
module gpio_pinctrl_dec
    import gpio_pinctrl_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    localparam int PORTS = (NUM_PINS + PINS_PER_PORT - 1) / PINS_PER_PORT;
    localparam int WORDS = (NUM_PINS + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;

    logic [3:0] region;
    logic [1:0] sub;
    logic       port_ok;

    always_comb begin
        region  = addr[9:6];
        sub     = addr[5:4];
        port_ok = (32'(addr[3:2]) < PORTS);

        dec.tgt  = TGT_NONE;
        dec.attr = ATTR_DIR;
        dec.op   = WOP_REPLACE;
        dec.port = addr[3:2];
        dec.idx  = addr[7:2];

        if (addr[1:0] == 2'b00) begin
            if (region < 4'd6) begin
                if (sub != 2'd3 && port_ok) begin
                    dec.tgt  = TGT_ATTR;
                    dec.attr = attr_e'(region[2:0]);
                    dec.op   = wop_e'(sub);
                end
            end else if (region == 4'd6) begin
                if (sub == 2'd0 && port_ok) begin
                    dec.tgt = TGT_DIN;
                end
            end else if (addr[9:8] == 2'd2) begin
                if (32'(addr[7:2]) < WORDS) begin
                    dec.tgt = TGT_MWORD;
                end
            end else if (addr[9:8] == 2'd3) begin
                if (32'(addr[7:2]) < NUM_PINS) begin
                    dec.tgt = TGT_MFIELD;
                end
            end
        end
    end

endmodule

// File: rtl/gpio_pinctrl_attr.sv
module gpio_pinctrl_attr
    import gpio_pinctrl_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  wop_e                 op,
    input  logic [1:0]           port,
    input  logic [15:0]          wdata,
    output logic [PADW-1:0]      bits_q
);

    localparam int PORTS = (NUM_PINS + PINS_PER_PORT - 1) / PINS_PER_PORT;
    localparam int PADW  = PORTS * PINS_PER_PORT;

    for (genvar g = 0; g < PORTS; g++) begin : g_port
        localparam int HI = ((NUM_PINS - g * PINS_PER_PORT) >= PINS_PER_PORT)
                            ? PINS_PER_PORT : (NUM_PINS - g * PINS_PER_PORT);
        localparam logic [15:0] VMASK = 16'((33'h1 << HI) - 33'h1);

        logic [15:0] grp_q;
        logic        hit;

        assign hit = wr_en && (32'(port) == g);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                grp_q <= '0;
            end else if (hit) begin
                unique case (op)
                    WOP_REPLACE: grp_q <= wdata & VMASK;
                    WOP_SET:     grp_q <= grp_q | (wdata & VMASK);
                    WOP_CLEAR:   grp_q <= grp_q & ~wdata;
                    default:     grp_q <= grp_q;
                endcase
            end
        end

        assign bits_q[g*PINS_PER_PORT +: PINS_PER_PORT] = grp_q;
    end

endmodule

// File: rtl/gpio_pinctrl_mode.sv
module gpio_pinctrl_mode
    import gpio_pinctrl_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       word_wr,
    input  logic                       field_wr,
    input  logic [5:0]                 idx,
    input  logic [MWORD_W-1:0]         wdata,
    output logic [NUM_PINS*MODE_W-1:0] mode_flat
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int WORD = i / FIELDS_PER_WORD;
        localparam int SLOT = i % FIELDS_PER_WORD;

        logic [MODE_W-1:0] field_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                field_q <= '0;
            end else if (word_wr && (32'(idx) == WORD)) begin
                field_q <= wdata[SLOT*MODE_W +: MODE_W];
            end else if (field_wr && (32'(idx) == i)) begin
                field_q <= wdata[MODE_W-1:0];
            end
        end

        assign mode_flat[i*MODE_W +: MODE_W] = field_q;
    end

endmodule

// File: rtl/gpio_pinctrl_sync.sv
module gpio_pinctrl_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/gpio_pinctrl_bank.sv
module gpio_pinctrl_bank
    import gpio_pinctrl_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic                       bus_ready,
    output logic                       bus_rvalid,
    output logic [31:0]                bus_rdata,
    input  logic [NUM_PINS-1:0]        pin_in,
    output logic [NUM_PINS-1:0]        pin_out,
    output logic [NUM_PINS-1:0]        pin_oe,
    output logic [NUM_PINS-1:0]        cfg_ien,
    output logic [NUM_PINS-1:0]        cfg_smt,
    output logic [NUM_PINS-1:0]        cfg_pull_en,
    output logic [NUM_PINS-1:0]        cfg_pull_up,
    output logic [NUM_PINS*MODE_W-1:0] cfg_mode
);

    localparam int PORTS = (NUM_PINS + PINS_PER_PORT - 1) / PINS_PER_PORT;
    localparam int PADW  = PORTS * PINS_PER_PORT;
    localparam int WORDS = (NUM_PINS + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;

    bus_st_e state_q, state_d;
    dec_t    dec;
    logic    accept, accept_wr, accept_rd;
    logic    wdata_unused;

    logic [PADW-1:0]     attr_q [N_ATTR];
    logic [NUM_PINS-1:0] din_sync;
    logic [PADW-1:0]     din_pad;
    logic [MWORD_W-1:0]  mword_all [WORDS];
    logic [MWORD_W-1:0]  mword_sel;
    logic [31:0]         rd_mux;
    logic [31:0]         rdata_q;

    assign wdata_unused = ^bus_wdata[31:16];

    gpio_pinctrl_dec #(.NUM_PINS(NUM_PINS)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    // ---------------- bus controller ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (bus_sel && !bus_wr) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        bus_ready  = 1'b0;
        bus_rvalid = 1'b0;
        unique case (state_q)
            BUS_IDLE: bus_ready  = 1'b1;
            BUS_RESP: bus_rvalid = 1'b1;
            default: ;
        endcase
    end

    assign accept    = bus_sel && bus_ready;
    assign accept_wr = accept && bus_wr;
    assign accept_rd = accept && !bus_wr;

    // ---------------- attribute banks ----------------
    for (genvar a = 0; a < N_ATTR; a++) begin : g_attr
        logic hit;
        assign hit = accept_wr && (dec.tgt == TGT_ATTR) && (dec.attr == attr_e'(a));

        gpio_pinctrl_attr #(.NUM_PINS(NUM_PINS)) u_attr (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (hit),
            .op     (dec.op),
            .port   (dec.port),
            .wdata  (bus_wdata[15:0]),
            .bits_q (attr_q[a])
        );
    end

    // ---------------- mode bank ----------------
    gpio_pinctrl_mode #(.NUM_PINS(NUM_PINS)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_wr   (accept_wr && (dec.tgt == TGT_MWORD)),
        .field_wr  (accept_wr && (dec.tgt == TGT_MFIELD)),
        .idx       (dec.idx),
        .wdata     (bus_wdata[MWORD_W-1:0]),
        .mode_flat (cfg_mode)
    );

    for (genvar w = 0; w < WORDS; w++) begin : g_mword
        for (genvar s = 0; s < FIELDS_PER_WORD; s++) begin : g_slot
            if (w * FIELDS_PER_WORD + s < NUM_PINS) begin : g_live
                assign mword_all[w][s*MODE_W +: MODE_W] =
                    cfg_mode[(w*FIELDS_PER_WORD + s)*MODE_W +: MODE_W];
            end else begin : g_pad
                assign mword_all[w][s*MODE_W +: MODE_W] = '0;
            end
        end
    end

    // ---------------- input synchronizer ----------------
    gpio_pinctrl_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (din_sync)
    );

    assign din_pad = PADW'(din_sync);

    // ---------------- read path ----------------
    always_comb begin
        mword_sel = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (32'(dec.idx) == w) mword_sel = mword_all[w];
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (dec.tgt)
            TGT_ATTR: begin
                for (int a = 0; a < N_ATTR; a++) begin
                    for (int p = 0; p < PORTS; p++) begin
                        if (dec.attr == attr_e'(a) && 32'(dec.port) == p)
                            rd_mux = {16'h0, attr_q[a][p*PINS_PER_PORT +: PINS_PER_PORT]};
                    end
                end
            end
            TGT_DIN: begin
                for (int p = 0; p < PORTS; p++) begin
                    if (32'(dec.port) == p)
                        rd_mux = {16'h0, din_pad[p*PINS_PER_PORT +: PINS_PER_PORT]};
                end
            end
            TGT_MWORD: rd_mux = 32'(mword_sel);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_q <= '0;
        else if (accept_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    // ---------------- pin side ----------------
    assign pin_out     = attr_q[int'(ATTR_DOUT)][NUM_PINS-1:0];
    assign cfg_ien     = attr_q[int'(ATTR_IEN)][NUM_PINS-1:0];
    assign cfg_smt     = attr_q[int'(ATTR_SMT)][NUM_PINS-1:0];
    assign cfg_pull_en = attr_q[int'(ATTR_PEN)][NUM_PINS-1:0];
    assign cfg_pull_up = attr_q[int'(ATTR_PSEL)][NUM_PINS-1:0];

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_oe
        assign pin_oe[i] = attr_q[int'(ATTR_DIR)][i] &&
                           (cfg_mode[i*MODE_W +: MODE_W] == '0);
    end

endmodule

// File: rtl/gpio_pinctrl_bank_chk.sv
module gpio_pinctrl_bank_chk
    import gpio_pinctrl_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_wr,
    input logic                       bus_ready,
    input logic                       bus_rvalid,
    input logic [NUM_PINS-1:0]        pin_out,
    input logic [NUM_PINS-1:0]        pin_oe,
    input logic [NUM_PINS*MODE_W-1:0] cfg_mode
);

    logic [NUM_PINS-1:0] gpio_fn;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_fn
        assign gpio_fn[i] = (cfg_mode[i*MODE_W +: MODE_W] == '0);
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && cfg_mode == '0));

    assert_oe_gpio_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~gpio_fn) == '0);

    assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel && bus_wr) |-> $stable(pin_out));

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel && bus_wr) |-> $stable(cfg_mode));

    assert_rvalid_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_sel && !bus_wr && bus_ready));

    assert_busy_in_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> !bus_ready);

endmodule

bind gpio_pinctrl_bank gpio_pinctrl_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_ready  (bus_ready),
    .bus_rvalid (bus_rvalid),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .cfg_mode   (cfg_mode)
);

// File: tb/gpio_pinctrl_bank_tb.sv
`timescale 1ns/1ps
module gpio_pinctrl_bank_tb;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_ready, bus_rvalid;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe, cfg_ien, cfg_smt, cfg_pull_en, cfg_pull_up;
    logic [3*N-1:0] cfg_mode;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    gpio_pinctrl_bank #(.NUM_PINS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .cfg_ien(cfg_ien), .cfg_smt(cfg_smt),
        .cfg_pull_en(cfg_pull_en), .cfg_pull_up(cfg_pull_up), .cfg_mode(cfg_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        while (!bus_ready) @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
        while (!bus_ready) @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        check("R11 rvalid after read", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset;
        check("R1 pin_oe", pin_oe, '0);
        check("R1 pin_out", pin_out, '0);
        check("R1 cfg_mode low", cfg_mode[31:0], '0);
        read_check("R1 dir read", 10'h000, 32'h0);
        read_check("R1 mode word read", 10'h204, 32'h0);
    endtask

    task automatic t_port_map;
        bus_write(10'h004, 32'hABCD_8001);
        read_check("R2 base replace, upper zero", 10'h004, 32'h0000_8001);
        @(negedge clk);
        check("R2 pins 16/31 output", pin_oe, 32'h8001_0000);
        bus_write(10'h040, 32'hFFFF_00F0);
        read_check("R5 dout read", 10'h040, 32'h0000_00F0);
        check("R5 pin_out", pin_out, 32'h0000_00F0);
    endtask

    task automatic t_set_alias;
        bus_write(10'h010, 32'h0000_0030);
        read_check("R3 set alias", 10'h000, 32'h0000_0030);
        bus_write(10'h010, 32'h0000_0001);
        read_check("R3 set keeps others", 10'h000, 32'h0000_0031);
    endtask

    task automatic t_clear_alias;
        bus_write(10'h020, 32'h0000_0010);
        read_check("R4 clear alias", 10'h000, 32'h0000_0021);
        check("R9 oe follows dir", pin_oe, 32'h8001_0021);
        bus_write(10'h060, 32'h0000_00A0);
        check("R4 dout clear", pin_out, 32'h0000_0050);
        bus_write(10'h054, 32'h0000_8000);
        check("R3 dout set port1", pin_out, 32'h8000_0050);
    endtask

    task automatic t_mode_field;
        bus_write(10'h314, 32'hFFFF_FFFB);
        read_check("R8 field pin5", 10'h204, 32'h0000_0003);
        check("R9 oe off when mode nonzero", pin_oe, 32'h8001_0001);
        bus_write(10'h31C, 32'h0000_0006);
        read_check("R8 field pin7 keeps pin5", 10'h204, 32'h0000_0183);
        check("R8 cfg_mode pin5", 32'(cfg_mode[17:15]), 32'd3);
        check("R8 cfg_mode pin7", 32'(cfg_mode[23:21]), 32'd6);
    endtask

    task automatic t_mode_word;
        bus_write(10'h218, 32'hFFFF_FFFF);
        read_check("R7 last word only live pins", 10'h218, 32'h0000_003F);
        check("R9 pin31 oe dropped", pin_oe, 32'h0001_0001);
        check("R7 cfg_mode pin31", 32'(cfg_mode[95:93]), 32'd7);
        bus_write(10'h200, 32'h1234_5678);
        read_check("R7 word replace", 10'h200, 32'h0000_5678);
        read_check("R7 other word untouched", 10'h204, 32'h0000_0183);
        check("R7 cfg_mode pin1", 32'(cfg_mode[5:3]), 32'd7);
    endtask

    task automatic t_input_sync;
        pin_in = 32'hDEAD_BEEF;
        @(negedge clk);
        read_check("R6 not yet through synchronizer", 10'h180, 32'h0000_0000);
        repeat (2) @(negedge clk);
        read_check("R6 din port0", 10'h180, 32'h0000_BEEF);
        read_check("R6 din port1", 10'h184, 32'h0000_DEAD);
        bus_write(10'h180, 32'h0);
        bus_write(10'h1A0, 32'hFFFF);
        read_check("R6 din ignores writes", 10'h180, 32'h0000_BEEF);
    endtask

    task automatic t_config_out;
        bus_write(10'h080, 32'h0000_00FF);
        bus_write(10'h0C4, 32'h0000_1234);
        bus_write(10'h100, 32'h0000_F0F0);
        bus_write(10'h150, 32'h0000_000F);
        check("R10 cfg_ien", cfg_ien, 32'h0000_00FF);
        check("R10 cfg_smt", cfg_smt, 32'h1234_0000);
        check("R10 cfg_pull_en", cfg_pull_en, 32'h0000_F0F0);
        check("R10 cfg_pull_up", cfg_pull_up, 32'h0000_000F);
        read_check("R10 pull select read", 10'h140, 32'h0000_000F);
    endtask

    task automatic t_unmapped;
        logic [3*N-1:0] mode_before;
        mode_before = cfg_mode;
        bus_write(10'h1C0, 32'hFFFF);
        read_check("R12 gap region", 10'h1C0, 32'h0);
        bus_write(10'h030, 32'hFFFF);
        read_check("R12 offset 0x30", 10'h030, 32'h0);
        bus_write(10'h008, 32'hFFFF);
        read_check("R12 port beyond pins", 10'h008, 32'h0);
        bus_write(10'h002, 32'hFFFF);
        read_check("R12 dir untouched", 10'h000, 32'h0000_0021);
        bus_write(10'h21C, 32'h7FFF);
        read_check("R12 mode word beyond pins", 10'h21C, 32'h0);
        bus_write(10'h380, 32'h7);
        check("R12 mode fields untouched", 32'(cfg_mode == mode_before), 32'd1);
    endtask

    task automatic t_handshake;
        logic [31:0] d;
        bus_read(10'h000, d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 10'h010; bus_wdata = 32'h0000_0100;
        check("R11 ready low during response", 32'(bus_ready), 32'd0);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R11 rvalid one cycle only", 32'(bus_rvalid), 32'd0);
        read_check("R11 write while busy ignored", 10'h000, 32'h0000_0021);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_port_map();
        t_set_alias();
        t_clear_alias();
        t_mode_field();
        t_mode_word();
        t_input_sync();
        t_config_out();
        t_unmapped();
        t_handshake();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R11 watchdog: actual=hung expected=complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule